// File: doc/BRIEF.md
# Per-Connection Session Key Lookup

This block selects the session key for each ATM cell from the cell's connection identifier. The cell sequencer presents the first header word of a cell. The block takes the VPI and VCI out of that word and matches them in parallel against a small on-chip associative table. Each table entry points to a key slot that holds the connection's 128-bit key, its cipher mode and its chaining flag. A local hit returns the result a fixed two cycles after the request is accepted. Lookups can be issued on every cycle, so a stream of cells that all belong to different connections keeps a steady rate.

When no valid local entry matches, the block asks an external match memory and key RAM. It raises a request that carries the connection identifier and waits for an answer. If no answer arrives within a bounded number of cycles, it returns a bypass result. A management port writes entries and invalidates them. One instance serves one traffic direction, so the transmit and receive cipher cores each get their own instance.

Top module: `skl_lookup`

## Requirements
- R1: The connection identifier is taken from the 32-bit header word as VPI = bits 27:20 and VCI = bits 19:4. The other header bits have no effect on the result.
- R2: A lookup request accepted in cycle t that hits a valid local entry gives `rsp_valid_o` in cycle t+2, with `rsp_hit_o`=1, `rsp_ext_o`=0 and that entry's key, mode and chaining flag. While only local hits occur, `lkp_ready_o` stays high and one request is accepted in every cycle.
- R3: An entry written with its valid bit cleared never matches. A lookup whose identifier has no valid local entry does not produce a local hit.
- R4: When several valid entries hold the same identifier, the entry with the lowest index supplies the result.
- R5: A management write in the same cycle as an accepted lookup affects only later lookups. The lookup already in flight returns the old entry contents.
- R6: On a local miss, `ext_req_o` rises two cycles after the request is accepted and carries the identifier on `ext_conn_o`. The identifier is held stable while the request is pending. `lkp_ready_o` is low from the cycle after the miss request is accepted until the external phase ends.
- R7: An external answer (`ext_rsp_valid_i` high) ends the external phase. The next cycle gives `rsp_valid_o`, with `rsp_ext_o`=1 and the hit flag, key, mode and chaining flag taken from the answer.
- R8: If no external answer arrives while `ext_req_o` has been high for TIMEOUT (default 64) cycles, the lookup completes with `rsp_hit_o`=0 and `rsp_ext_o`=1.
- R9: Every response with `rsp_hit_o`=0 has mode bypass, a chaining flag of 0 and an all-zero key. The mode codes are 0 = bypass, 1 = single DES and 2 = two-key TripleDES.
- R10: During and right after reset, `lkp_ready_o` is 1 and `rsp_valid_o` and `ext_req_o` are 0, and all table entries are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_req_i | input | 1 | Lookup request |
| lkp_hdr_i | input | 32 | First header word of the cell |
| lkp_ready_o | output | 1 | Lookup can be accepted |
| rsp_valid_o | output | 1 | Result valid (one-cycle pulse) |
| rsp_hit_o | output | 1 | Key found |
| rsp_ext_o | output | 1 | Result came from the external phase |
| rsp_mode_o | output | 2 | Cipher mode code |
| rsp_cbc_o | output | 1 | 1 = chained mode, 0 = block-by-block mode |
| rsp_key_o | output | 128 | Session key |
| mgmt_we_i | input | 1 | Entry write strobe |
| mgmt_idx_i | input | 4 | Entry index |
| mgmt_valid_i | input | 1 | Valid bit to write (0 invalidates the entry) |
| mgmt_conn_i | input | 24 | Identifier {VPI, VCI} |
| mgmt_mode_i | input | 2 | Mode code |
| mgmt_cbc_i | input | 1 | Chaining flag |
| mgmt_key_i | input | 128 | Key material |
| ext_req_o | output | 1 | External lookup pending |
| ext_conn_o | output | 24 | Identifier sent to the external table |
| ext_rsp_valid_i | input | 1 | External answer strobe |
| ext_rsp_hit_i | input | 1 | External table found the identifier |
| ext_rsp_mode_i | input | 2 | External mode code |
| ext_rsp_cbc_i | input | 1 | External chaining flag |
| ext_rsp_key_i | input | 128 | External key |

## Verification
The bench goes after priority among duplicate identifiers: a design with the wrong priority returns the key from the higher slot. It checks a lookup that collides with a write to its own entry, where a design with a read-after-write path would return the new key too early. It checks header bits outside the VPI/VCI fields, which a wrong field slice would turn into false misses. It sweeps the external phase over answer delays and the full timeout. An off-by-one counter shows up there as a request that lasts 63 or 65 cycles, and missing masking shows up as stale key bytes on a miss.

// File: rtl/skl_pkg.sv
package skl_pkg;
  localparam int VPI_W  = 8;
  localparam int VCI_W  = 16;
  localparam int CONN_W = VPI_W + VCI_W;
  localparam int KEY_W  = 128;
  localparam int MODE_W = 2;

  localparam logic [MODE_W-1:0] MODE_BYPASS = 2'd0;
  localparam logic [MODE_W-1:0] MODE_DES    = 2'd1;
  localparam logic [MODE_W-1:0] MODE_TDES2  = 2'd2;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              cbc;
    logic [KEY_W-1:0]  key;
  } kslot_t;

  typedef enum logic {ST_IDLE, ST_EXT} lkp_state_e;
endpackage

// File: rtl/skl_cam.sv
module skl_cam
  import skl_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic              wvalid_i,
  input  logic [CONN_W-1:0] wconn_i,
  input  logic [CONN_W-1:0] qconn_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [ENTRIES-1:0]   vld_q;
  logic [CONN_W-1:0]    conn_q [ENTRIES];
  logic [ENTRIES-1:0]   match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        conn_q[g] <= '0;
      end else if (we_i && widx_i == IDX_W'(g)) begin
        vld_q[g]  <= wvalid_i;
        conn_q[g] <= wconn_i;
      end
    end
    assign match[g] = vld_q[g] && (conn_q[g] == qconn_i);
  end

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) idx_o = IDX_W'(i);
    end
  end
  assign hit_o = |match;
endmodule

// File: rtl/skl_key_ram.sv
module skl_key_ram
  import skl_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  kslot_t           wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output kslot_t           rdata_o
);
  kslot_t mem_q [ENTRIES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end
  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/skl_lookup.sv
module skl_lookup
  import skl_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int TIMEOUT = 64,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int CNT_W = $clog2(TIMEOUT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_req_i,
  input  logic [31:0]       lkp_hdr_i,
  output logic              lkp_ready_o,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_ext_o,
  output logic [MODE_W-1:0] rsp_mode_o,
  output logic              rsp_cbc_o,
  output logic [KEY_W-1:0]  rsp_key_o,
  input  logic              mgmt_we_i,
  input  logic [IDX_W-1:0]  mgmt_idx_i,
  input  logic              mgmt_valid_i,
  input  logic [CONN_W-1:0] mgmt_conn_i,
  input  logic [MODE_W-1:0] mgmt_mode_i,
  input  logic              mgmt_cbc_i,
  input  logic [KEY_W-1:0]  mgmt_key_i,
  output logic              ext_req_o,
  output logic [CONN_W-1:0] ext_conn_o,
  input  logic              ext_rsp_valid_i,
  input  logic              ext_rsp_hit_i,
  input  logic [MODE_W-1:0] ext_rsp_mode_i,
  input  logic              ext_rsp_cbc_i,
  input  logic [KEY_W-1:0]  ext_rsp_key_i
);
  logic [CONN_W-1:0] q_conn;
  logic              cam_hit, accept;
  logic [IDX_W-1:0]  cam_idx;
  kslot_t            ram_rd, mgmt_slot;
  logic              s1_vld, s1_hit;
  logic [CONN_W-1:0] s1_conn;
  kslot_t            s1_slot;
  lkp_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;

  assign q_conn    = {lkp_hdr_i[27:20], lkp_hdr_i[19:4]};
  assign mgmt_slot = '{mode: mgmt_mode_i, cbc: mgmt_cbc_i, key: mgmt_key_i};

  skl_cam #(.ENTRIES(ENTRIES)) u_cam (
    .clk_i, .rst_ni,
    .we_i(mgmt_we_i), .widx_i(mgmt_idx_i), .wvalid_i(mgmt_valid_i),
    .wconn_i(mgmt_conn_i), .qconn_i(q_conn),
    .hit_o(cam_hit), .idx_o(cam_idx)
  );

  skl_key_ram #(.ENTRIES(ENTRIES)) u_ram (
    .clk_i, .we_i(mgmt_we_i), .widx_i(mgmt_idx_i), .wdata_i(mgmt_slot),
    .ridx_i(cam_idx), .rdata_o(ram_rd)
  );

  assign lkp_ready_o = (state_q == ST_IDLE) && !(s1_vld && !s1_hit);
  assign accept      = lkp_req_i && lkp_ready_o;
  assign ext_req_o   = (state_q == ST_EXT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld      <= 1'b0;
      s1_hit      <= 1'b0;
      s1_conn     <= '0;
      s1_slot     <= '0;
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      ext_conn_o  <= '0;
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_ext_o   <= 1'b0;
      rsp_mode_o  <= MODE_BYPASS;
      rsp_cbc_o   <= 1'b0;
      rsp_key_o   <= '0;
    end else begin
      // stage 1 samples table before a same-cycle write lands
      s1_vld <= accept;
      if (accept) begin
        s1_hit  <= cam_hit;
        s1_conn <= q_conn;
        s1_slot <= cam_hit ? ram_rd : '0;
      end
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (s1_vld && s1_hit) begin
            rsp_valid_o <= 1'b1;
            rsp_hit_o   <= 1'b1;
            rsp_ext_o   <= 1'b0;
            rsp_mode_o  <= s1_slot.mode;
            rsp_cbc_o   <= s1_slot.cbc;
            rsp_key_o   <= s1_slot.key;
          end else if (s1_vld) begin
            state_q    <= ST_EXT;
            ext_conn_o <= s1_conn;
            cnt_q      <= '0;
          end
        end
        ST_EXT: begin
          if (ext_rsp_valid_i || cnt_q == CNT_W'(TIMEOUT - 1)) begin
            state_q     <= ST_IDLE;
            rsp_valid_o <= 1'b1;
            rsp_ext_o   <= 1'b1;
            rsp_hit_o   <= ext_rsp_valid_i && ext_rsp_hit_i;
            if (ext_rsp_valid_i && ext_rsp_hit_i) begin
              rsp_mode_o <= ext_rsp_mode_i;
              rsp_cbc_o  <= ext_rsp_cbc_i;
              rsp_key_o  <= ext_rsp_key_i;
            end else begin
              rsp_mode_o <= MODE_BYPASS;
              rsp_cbc_o  <= 1'b0;
              rsp_key_o  <= '0;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/skl_lookup_chk.sv
module skl_lookup_chk #(
  parameter int TIMEOUT = 64,
  parameter int KEY_W   = 128,
  parameter int CONN_W  = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lkp_req_i,
  input logic              lkp_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic              rsp_ext_o,
  input logic [1:0]        rsp_mode_o,
  input logic              rsp_cbc_o,
  input logic [KEY_W-1:0]  rsp_key_o,
  input logic              ext_req_o,
  input logic [CONN_W-1:0] ext_conn_o
);
  int unsigned ext_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ext_cnt <= 0;
    else if (ext_req_o) ext_cnt <= ext_cnt + 1;
    else                ext_cnt <= 0;
  end

  // R2
  local_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ext_o |-> $past(lkp_req_i && lkp_ready_o, 2));
  // R9
  miss_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_hit_o |-> rsp_mode_o == 2'd0 && !rsp_cbc_o && rsp_key_o == '0);
  // R6
  ext_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_o |-> !lkp_ready_o);
  // R6
  ext_conn_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_o && $past(ext_req_o) |-> $stable(ext_conn_o));
  // R8
  ext_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_o |-> ext_cnt < TIMEOUT);
  // R7
  ext_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ext_req_o) |-> rsp_valid_o && rsp_ext_o);
endmodule

bind skl_lookup skl_lookup_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lkp_req_i(lkp_req_i), .lkp_ready_o(lkp_ready_o),
  .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_ext_o(rsp_ext_o),
  .rsp_mode_o(rsp_mode_o), .rsp_cbc_o(rsp_cbc_o), .rsp_key_o(rsp_key_o),
  .ext_req_o(ext_req_o), .ext_conn_o(ext_conn_o)
);

// File: tb/skl_lookup_bench.sv
module skl_lookup_bench;
  localparam int N = 16;
  localparam int TMO = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lkp_req = 0; logic [31:0] lkp_hdr = '0;
  logic lkp_ready, rsp_valid, rsp_hit, rsp_ext, rsp_cbc;
  logic [1:0] rsp_mode; logic [127:0] rsp_key;
  logic mg_we = 0, mg_valid = 0, mg_cbc = 0; logic [3:0] mg_idx = '0;
  logic [23:0] mg_conn = '0; logic [1:0] mg_mode = '0; logic [127:0] mg_key = '0;
  logic ext_req; logic [23:0] ext_conn;
  logic ex_vld = 0, ex_hit = 0, ex_cbc = 0; logic [1:0] ex_mode = '0; logic [127:0] ex_key = '0;

  int checks = 0, fails = 0;
  bit m_vld [N]; logic [23:0] m_conn [N]; logic [1:0] m_mode [N]; bit m_cbc [N]; logic [127:0] m_key [N];

  always #10 clk = ~clk;

  skl_lookup u_skl_lookup (
    .clk_i(clk), .rst_ni(rst_n), .lkp_req_i(lkp_req), .lkp_hdr_i(lkp_hdr), .lkp_ready_o(lkp_ready),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_ext_o(rsp_ext), .rsp_mode_o(rsp_mode),
    .rsp_cbc_o(rsp_cbc), .rsp_key_o(rsp_key), .mgmt_we_i(mg_we), .mgmt_idx_i(mg_idx),
    .mgmt_valid_i(mg_valid), .mgmt_conn_i(mg_conn), .mgmt_mode_i(mg_mode), .mgmt_cbc_i(mg_cbc),
    .mgmt_key_i(mg_key), .ext_req_o(ext_req), .ext_conn_o(ext_conn), .ext_rsp_valid_i(ex_vld),
    .ext_rsp_hit_i(ex_hit), .ext_rsp_mode_i(ex_mode), .ext_rsp_cbc_i(ex_cbc), .ext_rsp_key_i(ex_key)
  );

  function automatic logic [23:0] conn_of(int i);
    return {8'(i * 3 + 1), 16'(16'h100 + i * 17)};
  endfunction
  function automatic logic [127:0] key_of(int i, int s);
    return {32'(i * 32'h01010101 + s), 32'(32'hDEAD0000 + i), 32'(s * 7 + 3), 32'(i ^ 32'h5555)};
  endfunction
  function automatic logic [31:0] hdr_of(logic [23:0] c, logic [3:0] junk);
    return {junk, c, junk};
  endfunction
  function automatic int ref_idx(logic [23:0] c);
    for (int i = 0; i < N; i++) if (m_vld[i] && m_conn[i] == c) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string tag, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  task automatic mgmt_wr(int i, bit v, logic [23:0] c, logic [1:0] md, bit cb, logic [127:0] k);
    @(negedge clk);
    mg_we = 1; mg_idx = 4'(i); mg_valid = v; mg_conn = c; mg_mode = md; mg_cbc = cb; mg_key = k;
    @(negedge clk);
    mg_we = 0;
    m_vld[i] = v; m_conn[i] = c; m_mode[i] = md; m_cbc[i] = cb; m_key[i] = k;
  endtask

  task automatic chk_local(logic [23:0] c, string tag);
    int r = ref_idx(c);
    chk(rsp_valid && rsp_hit && !rsp_ext, tag,
        $sformatf("hit v=%0b h=%0b e=%0b exp 1 1 0 conn=%h", rsp_valid, rsp_hit, rsp_ext, c));
    if (r >= 0)
      chk(rsp_key == m_key[r] && rsp_mode == m_mode[r] && rsp_cbc == m_cbc[r], tag,
          $sformatf("key=%h mode=%0d cbc=%0b exp key=%h mode=%0d cbc=%0b",
                    rsp_key, rsp_mode, rsp_cbc, m_key[r], m_mode[r], m_cbc[r]));
    else chk(0, tag, $sformatf("ref has no entry for %h", c));
  endtask

  // pipelined stream over a list of entry indices
  task automatic stream(int ids [], logic [3:0] junk, string tag);
    for (int k = 0; k < ids.size() + 2; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        chk_local(conn_of(ids[k-2]), tag);
        chk(lkp_ready, "R2", $sformatf("ready=%0b exp 1 during hit stream", lkp_ready));
      end
      if (k < ids.size()) begin lkp_req = 1; lkp_hdr = hdr_of(conn_of(ids[k]), junk); end
      else lkp_req = 0;
    end
  endtask

  // miss path; dly<0 means never answer
  task automatic ext_lookup(logic [23:0] c, int dly, bit eh, logic [1:0] em, bit ec, logic [127:0] ek);
    int hi = 0; bit got = 0;
    @(negedge clk); lkp_req = 1; lkp_hdr = hdr_of(c, 4'h0);
    @(negedge clk); lkp_req = 0;
    chk(!lkp_ready && !ext_req && !rsp_valid, "R6",
        $sformatf("after miss ready=%0b ext=%0b exp 0 0", lkp_ready, ext_req));
    @(negedge clk);
    chk(ext_req && ext_conn == c, "R6", $sformatf("ext_req=%0b conn=%h exp 1 %h", ext_req, ext_conn, c));
    chk(!lkp_ready, "R6", $sformatf("ready=%0b exp 0 while external", lkp_ready));
    for (int n = 0; n < 200; n++) begin
      if (ext_req) hi++;
      if (n == dly) begin ex_vld = 1; ex_hit = eh; ex_mode = em; ex_cbc = ec; ex_key = ek; end
      @(negedge clk);
      ex_vld = 0;
      if (rsp_valid) begin got = 1; break; end
    end
    if (dly < 0) begin
      chk(got && hi == TMO, "R8", $sformatf("got=%0b req_cycles=%0d exp 1 %0d", got, hi, TMO));
      chk(!rsp_hit && rsp_ext, "R8", $sformatf("hit=%0b ext=%0b exp 0 1", rsp_hit, rsp_ext));
    end else begin
      chk(got && hi == dly + 1 && rsp_ext, "R7",
          $sformatf("got=%0b req_cycles=%0d ext=%0b exp 1 %0d 1", got, hi, rsp_ext, dly + 1));
      chk(rsp_hit == eh, "R7", $sformatf("hit=%0b exp %0b", rsp_hit, eh));
      if (eh) chk(rsp_key == ek && rsp_mode == em && rsp_cbc == ec, "R7",
                  $sformatf("key=%h mode=%0d exp %h %0d", rsp_key, rsp_mode, ek, em));
    end
    if (!rsp_hit) chk(rsp_mode == 2'd0 && !rsp_cbc && rsp_key == '0, "R9",
                      $sformatf("miss mode=%0d cbc=%0b key=%h exp 0 0 0", rsp_mode, rsp_cbc, rsp_key));
    @(negedge clk);
    chk(lkp_ready && !ext_req && !rsp_valid, "R6",
        $sformatf("post ready=%0b ext=%0b v=%0b exp 1 0 0", lkp_ready, ext_req, rsp_valid));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int ord [];
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    repeat (3) @(negedge clk);
    chk(lkp_ready && !rsp_valid && !ext_req, "R10",
        $sformatf("in reset ready=%0b v=%0b ext=%0b exp 1 0 0", lkp_ready, rsp_valid, ext_req));
    rst_n = 1;
    @(negedge clk);
    chk(lkp_ready && !rsp_valid && !ext_req, "R10",
        $sformatf("post reset ready=%0b v=%0b ext=%0b", lkp_ready, rsp_valid, ext_req));
    // R10: empty table misses
    ext_lookup(conn_of(0), 0, 0, 2'd0, 0, '0);

    for (int i = 0; i < N; i++) mgmt_wr(i, 1, conn_of(i), 2'(i % 3), 1'(i % 2), key_of(i, 1));

    ord = new [N];
    for (int i = 0; i < N; i++) ord[i] = i;
    stream(ord, 4'h0, "R2");
    for (int i = 0; i < N; i++) ord[i] = (i * 7 + 3) % N;
    stream(ord, 4'h0, "R2");
    // R1: bits outside the VPI/VCI fields set
    stream(ord, 4'hF, "R1");
    for (int i = 0; i < N; i++) ord[i] = (i % 2 == 0) ? i / 2 : N - 1 - i / 2;
    stream(ord, 4'hA, "R1");

    // R4: duplicate identifier, lower slot must win
    mgmt_wr(5, 1, conn_of(11), 2'd2, 1, key_of(5, 9));
    ord = new [3]; ord[0] = 11; ord[1] = 2; ord[2] = 11;
    stream(ord, 4'h0, "R4");
    chk(ref_idx(conn_of(11)) == 5, "R4", "model priority");
    mgmt_wr(1, 1, conn_of(11), 2'd1, 0, key_of(1, 4));
    ord = new [1]; ord[0] = 11;
    stream(ord, 4'h0, "R4");

    // R5: write and lookup of same entry in one cycle
    @(negedge clk);
    lkp_req = 1; lkp_hdr = hdr_of(conn_of(4), 4'h0);
    mg_we = 1; mg_idx = 4'd4; mg_valid = 1; mg_conn = conn_of(4); mg_mode = 2'd2; mg_cbc = 1; mg_key = key_of(4, 77);
    @(negedge clk);
    lkp_req = 0; mg_we = 0;
    @(negedge clk);
    chk_local(conn_of(4), "R5");
    m_mode[4] = 2'd2; m_cbc[4] = 1; m_key[4] = key_of(4, 77);
    ord[0] = 4;
    stream(ord, 4'h0, "R5");

    // R3: invalidated entry falls to the external path
    mgmt_wr(7, 0, conn_of(7), 2'd1, 1, key_of(7, 1));
    ext_lookup(conn_of(7), 0, 0, 2'd1, 1, key_of(7, 3));
    for (int d = 0; d < 6; d++)
      ext_lookup(24'hABC000 + 24'(d), d * 5, 1, 2'(d % 3), 1'(d % 2), key_of(40 + d, d));
    ext_lookup(24'hFF0001, TMO - 1, 1, 2'd2, 1, key_of(90, 1));
    ext_lookup(24'hFF0002, -1, 0, 2'd0, 0, '0);
    // R7: external miss report
    ext_lookup(conn_of(7), 3, 0, 2'd2, 1, key_of(3, 3));
    // table still serves hits after external phases
    ord = new [4]; ord[0] = 0; ord[1] = 15; ord[2] = 8; ord[3] = 3;
    stream(ord, 4'h0, "R2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule